// File: doc/BRIEF.md
# Two-Wire Bit-Rate Clock Generator

This block sets the bit rate of a two-wire serial controller. It divides the system clock through a chain of four counters: a programmable high-period count, a fixed divide-by-ten, a programmable M divider and a power-of-two N divider. At the end of every half period of the serial clock it raises `osc_tick` for one cycle and flips `scl_phase`. The byte engine uses these two outputs to decide when to drive or sample the bus lines.

Software works out the divisor values. It writes an 8-bit high-period value and a control byte that holds both the M and N fields. Each write goes into a staging register. The staged values move into the running dividers only when a full serial-clock period completes, so a period is never cut short.

One half period lasts (max(THP,5)+1) · 10 · (M+1) · 2^N system cycles. The serial clock frequency is therefore the system clock divided by twice that figure.

Top module: `twi_rate_gen`

## Requirements
- R1: After reset `osc_tick` and `scl_phase` are 0. The running configuration is THP=0x18, M=2, N=0, so the first `osc_tick` comes 750 cycles after reset is released.
- R2: Consecutive `osc_tick` pulses are (THP_eff+1)·10·(M+1)·2^N cycles apart, where THP_eff is the running high-period value.
- R3: `osc_tick` is high for exactly one cycle at a time.
- R4: `scl_phase` flips in the same cycle that `osc_tick` is high and holds its value in every other cycle. The first tick after reset sets it to 1.
- R5: In the control byte, M is bits 6:3 and N is bits 2:0. Bit 7 has no effect on the divide ratio.
- R6: A high-period value below 5 is run as 5.
- R7: Staged values take effect only at the tick where `scl_phase` returns to 0. Every half period that began before that tick keeps the old ratio, including a half period in which the write landed.
- R8: The high-period register and the control register are written separately. Writing one leaves the other's staged and running value unchanged.
- R9: When a register is written more than once within a period, the last value written before the boundary is the one that gets applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thp_we | input | 1 | Write strobe for the high-period value |
| thp_wdata | input | 8 | High-period value to stage |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: M in bits 6:3, N in bits 2:0 |
| osc_tick | output | 1 | One-cycle pulse at each half-period boundary |
| scl_phase | output | 1 | Serial-clock phase, flips at every tick |

## Verification
The assertions are checked on every cycle. They cover the one-cycle width of the tick, the rule that `scl_phase` changes exactly when `osc_tick` is high, the running configuration holding steady between full-period boundaries, the floor of 5 on the running high-period value, and each stage counter staying within its limit. The exact tick spacing for a given field encoding can only be shown by the bench scenarios. So can the boundary at which a staged write starts to apply, for writes that land in either half, and the facts that bit 7 is ignored, that small high-period values are clamped, and that the last of several writes is the one that wins.

// File: rtl/twi_rate_pkg.sv
package twi_rate_pkg;

   // Fixed decade stage of the divider chain
   localparam int unsigned DECADE_DIV = 10;
   // Number of chained counter stages
   localparam int unsigned NUM_STAGES = 4;

   typedef enum int unsigned {
      STG_HIGH   = 0,
      STG_DECADE = 1,
      STG_MDIV   = 2,
      STG_NDIV   = 3
   } stage_e;

   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/twi_rate_cfg.sv
module twi_rate_cfg #(
   parameter int unsigned THP_W   = 8,
   parameter int unsigned M_W     = 4,
   parameter int unsigned N_W     = 3,
   parameter int unsigned CTL_W   = 8,
   parameter int unsigned THP_MIN = 5,
   parameter int unsigned THP_RST = 8'h18,
   parameter int unsigned M_RST   = 2,
   parameter int unsigned N_RST   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thp_we,
   input  logic [THP_W-1:0] thp_wd,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wd,
   input  logic             load_i,
   output logic [THP_W-1:0] thp_act,
   output logic [M_W-1:0]   m_act,
   output logic [N_W-1:0]   n_act
);

   localparam int unsigned FLD_W = M_W + N_W;

   logic [THP_W-1:0] thp_pend;
   logic [M_W-1:0]   m_pend;
   logic [N_W-1:0]   n_pend;
   logic [THP_W-1:0] thp_clamped;

   generate
      if (FLD_W > CTL_W) begin : g_bad_fields
         $error("M and N fields do not fit in the control byte");
      end
      if (THP_MIN < 1 || THP_MIN >= (1 << THP_W)) begin : g_bad_min
         $error("THP_MIN out of range");
      end
      if (FLD_W < CTL_W) begin : g_spare
         logic unused_ctl_bits;
         assign unused_ctl_bits = ^ctl_wd[CTL_W-1:FLD_W];
      end
   endgenerate

   // Staging registers, written at any time
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thp_pend <= THP_W'(THP_RST);
         m_pend   <= M_W'(M_RST);
         n_pend   <= N_W'(N_RST);
      end else begin
         if (thp_we) thp_pend <= thp_wd;
         if (ctl_we) begin
            m_pend <= ctl_wd[FLD_W-1:N_W];
            n_pend <= ctl_wd[N_W-1:0];
         end
      end
   end

   assign thp_clamped = (thp_pend < THP_W'(THP_MIN)) ? THP_W'(THP_MIN) : thp_pend;

   // Running registers, copied only at a full-period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thp_act <= THP_W'(THP_RST);
         m_act   <= M_W'(M_RST);
         n_act   <= N_W'(N_RST);
      end else if (load_i) begin
         thp_act <= thp_clamped;
         m_act   <= m_pend;
         n_act   <= n_pend;
      end
   end

   // R7: running values move only on a boundary load
   p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable({thp_act, m_act, n_act}));

   // R6: the running high period never drops below the floor
   p_thp_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      thp_act >= THP_W'(THP_MIN));

endmodule

// File: rtl/twi_rate_stage.sv
module twi_rate_stage #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv_i,
   input  logic [CW-1:0] lim_i,
   output logic          term_o
);

   logic [CW-1:0] cnt;

   assign term_o = (cnt == lim_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (adv_i) cnt <= term_o ? '0 : cnt + 1'b1;
   end

   // R2: a stage never runs past its terminal count
   p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim_i);

endmodule

// File: rtl/twi_rate_gen.sv
module twi_rate_gen #(
   parameter int unsigned THP_W   = 8,
   parameter int unsigned M_W     = 4,
   parameter int unsigned N_W     = 3,
   parameter int unsigned CTL_W   = 8,
   parameter int unsigned THP_MIN = 5,
   parameter int unsigned THP_RST = 8'h18,
   parameter int unsigned M_RST   = 2,
   parameter int unsigned N_RST   = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thp_we,
   input  logic [THP_W-1:0] thp_wdata,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic             osc_tick,
   output logic             scl_phase
);
   import twi_rate_pkg::*;

   localparam int unsigned NS = NUM_STAGES;
   localparam int unsigned CW = imax(imax(THP_W, M_W),
                                     imax((1 << N_W) - 1, $clog2(DECADE_DIV)));

   logic [THP_W-1:0] thp_act;
   logic [M_W-1:0]   m_act;
   logic [N_W-1:0]   n_act;
   logic [CW-1:0]    lim  [NS];
   logic [NS-1:0]    term;
   logic [NS:0]      adv;
   logic             wrap;
   logic             load;

   generate
      if (DECADE_DIV < 2) begin : g_bad_decade
         $error("decade stage must divide by at least two");
      end
   endgenerate

   assign wrap = adv[NS];
   assign load = wrap & scl_phase;

   twi_rate_cfg #(
      .THP_W(THP_W), .M_W(M_W), .N_W(N_W), .CTL_W(CTL_W),
      .THP_MIN(THP_MIN), .THP_RST(THP_RST), .M_RST(M_RST), .N_RST(N_RST)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .thp_we  (thp_we),
      .thp_wd  (thp_wdata),
      .ctl_we  (ctl_we),
      .ctl_wd  (ctl_wdata),
      .load_i  (load),
      .thp_act (thp_act),
      .m_act   (m_act),
      .n_act   (n_act)
   );

   assign lim[STG_HIGH]   = CW'(thp_act);
   assign lim[STG_DECADE] = CW'(DECADE_DIV - 1);
   assign lim[STG_MDIV]   = CW'(m_act);
   assign lim[STG_NDIV]   = CW'((1 << n_act) - 1);

   assign adv[0] = 1'b1;

   generate
      for (genvar i = 0; i < NS; i++) begin : g_stage
         twi_rate_stage #(.CW(CW)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (adv[i]),
            .lim_i  (lim[i]),
            .term_o (term[i])
         );
         assign adv[i+1] = adv[i] & term[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_tick  <= 1'b0;
         scl_phase <= 1'b0;
      end else begin
         osc_tick  <= wrap;
         scl_phase <= scl_phase ^ wrap;
      end
   end

   // R3: the tick is a single-cycle pulse
   p_tick_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |=> !osc_tick);

   // R4: phase moves with the tick
   p_phase_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      osc_tick |-> !$stable(scl_phase));

   // R4: phase rests between ticks
   p_phase_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_tick |-> $stable(scl_phase));

endmodule

// File: tb/twi_rate_gen_tb.sv
module twi_rate_gen_tb;

   typedef struct {
      int    len;
      bit    ph;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       thp_we = 1'b0;
   logic [7:0] thp_wdata = '0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       osc_tick;
   logic       scl_phase;

   exp_t q[$];
   int   checks = 0;
   int   fails = 0;
   bit   done = 1'b0;
   int   cur;
   int   pthp;
   int   pctl;

   always #10 clk = ~clk;

   twi_rate_gen u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .thp_we    (thp_we),
      .thp_wdata (thp_wdata),
      .ctl_we    (ctl_we),
      .ctl_wdata (ctl_wdata),
      .osc_tick  (osc_tick),
      .scl_phase (scl_phase)
   );

   // Expected half period from the requirement formula (R2, R5, R6)
   function automatic int half_len(input int thp, input int ctl);
      int t = (thp < 5) ? 5 : thp;
      int m = (ctl >> 3) & 15;
      int n = ctl & 7;
      return (t + 1) * 10 * (m + 1) * (1 << n);
   endfunction

   function automatic void push(input int len, input bit ph, input string tag);
      exp_t e;
      e.len = len; e.ph = ph; e.tag = tag;
      q.push_back(e);
   endfunction

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic write_thp(input int v);
      thp_we = 1'b1; thp_wdata = 8'(v);
      @(negedge clk);
      thp_we = 1'b0;
      pthp = v;
   endtask

   task automatic write_ctl(input int v);
      ctl_we = 1'b1; ctl_wdata = 8'(v);
      @(negedge clk);
      ctl_we = 1'b0;
      pctl = v;
   endtask

   // Monitor: measure tick spacing and phase, compare with the scoreboard
   initial begin
      int  cyc = 0;
      bit  prev = 1'b0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            cyc = 0; prev = 1'b0;
         end else begin
            cyc++;
            if (prev) begin
               checks++;
               if (osc_tick) begin
                  fails++;
                  $display("FAIL R3 tick width: actual osc_tick=%0b expected 0", osc_tick);
               end
            end
            if (osc_tick) begin
               checks++;
               if (q.size() == 0) begin
                  fails++;
                  $display("FAIL R2 unexpected tick: actual interval %0d expected none", cyc);
               end else begin
                  e = q.pop_front();
                  if (cyc != e.len || scl_phase != e.ph) begin
                     fails++;
                     $display("FAIL %s interval/phase: actual %0d/%0b expected %0d/%0b",
                              e.tag, cyc, scl_phase, e.len, e.ph);
                  end
               end
               cyc = 0;
            end
            prev = osc_tick;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual run still going, expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   // Driver
   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      checks++;
      if (osc_tick !== 1'b0) begin
         fails++; $display("FAIL R1 reset osc_tick: actual %0b expected 0", osc_tick);
      end
      checks++;
      if (scl_phase !== 1'b0) begin
         fails++; $display("FAIL R1 reset scl_phase: actual %0b expected 0", scl_phase);
      end
      pthp = 8'h18; pctl = 8'h10;
      cur = half_len(pthp, pctl);
      push(750, 1'b1, "R1");
      #5 rst_n = 1'b1;
      drain();

      // Write just after the phase-1 tick: old ratio closes the period (R2 R7)
      write_thp(5); write_ctl(8'h00);
      push(cur, 1'b0, "R7");
      cur = half_len(pthp, pctl);
      push(cur, 1'b1, "R2");
      drain();

      // Write in the first half of a period: both halves keep the old ratio.
      // THP=2 clamps to 5 (R6); bit 7 set, M=1, N=1 (R5)
      push(cur, 1'b0, "R4");
      drain();
      write_thp(2); write_ctl(8'h89);
      push(cur, 1'b1, "R7");
      push(cur, 1'b0, "R7");
      cur = half_len(pthp, pctl);
      push(cur, 1'b1, "R5 R6");
      drain();

      // Control byte only; staged THP is kept (R8)
      write_ctl(8'h12);
      push(cur, 1'b0, "R7");
      cur = half_len(pthp, pctl);
      push(cur, 1'b1, "R8");
      drain();

      // Two THP writes in one period: the last one applies (R9)
      write_thp(200);
      repeat (3) @(negedge clk);
      write_thp(7);
      push(cur, 1'b0, "R7");
      cur = half_len(pthp, pctl);
      push(cur, 1'b1, "R9");
      drain();

      // Largest M, N=0 (R5)
      write_ctl(8'h78);
      push(cur, 1'b0, "R7");
      cur = half_len(pthp, pctl);
      push(cur, 1'b1, "R5");
      push(cur, 1'b0, "R2");
      drain();

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule